// File: doc/BRIEF.md
# Three-State Write-Back Snooping Cache Controller

This block is a small direct-mapped cache that keeps its lines coherent with the other caches on a shared bus, using an invalidation scheme with three line states. The states are Invalid (no copy), Shared (a clean copy that other caches may also hold) and Modified (the only copy, and dirty). A processor port accepts one read or write at a time. When the line does not hold the needed permission, the controller requests the bus with a read, read-for-ownership, upgrade or write-back command. It applies the arbiter's grant in the same cycle that the grant arrives.

The snoop port carries the transactions of other caches. A snooped request that hits a dirty line drives the line's data onto a flush output one cycle later, and the line is then downgraded or invalidated. Snoops take priority over the local request in every cycle. The local request's bus command is derived anew from the line state in every cycle, so a snoop that lands while the request waits for the bus changes what is asked for.

Top module: `msi_snoop_ctrl`

## Requirements
- R1: After reset every line is Invalid. `cpu_req_ready` is 1, and `bus_req_valid`, `flush_valid` and `cpu_resp_valid` are 0.
- R2: A read that misses (line Invalid, or holding another tag that is clean) requests command 0 (read) with the request address. On the grant cycle the line is filled from `bus_fill_data` in Shared, and the response then returns that data.
- R3: A write that misses requests command 1 (read-for-ownership). On grant the line is filled in Modified and the write is applied, so a later read returns the written data with no bus request.
- R4: A write to a Shared line with a matching tag requests command 2 (upgrade). On grant the line becomes Modified.
- R5: A read hit on a Shared or Modified line, and a write hit on a Modified line, complete with no bus request. `cpu_resp_valid` rises two cycles after the request is accepted and lasts one cycle. A write's response returns the written data.
- R6: A miss whose index holds a Modified line with another tag first requests command 3 (write-back), carrying the victim's address and data. It then requests the miss command. A clean victim is replaced with no write-back.
- R7: A snooped command 0 that hits a Modified line raises `flush_valid` one cycle later, with the snoop address and the line data. The line then becomes Shared, or Invalid when the parameter MIGRATORY is 1.
- R8: A snooped command 1 or 2 that hits a held line makes it Invalid. If the line was Modified, its data is flushed first, one cycle later. A snoop that does not hit causes no flush and no change.
- R9: A pending upgrade whose line is invalidated by a snoop before the grant is requested again as command 1 (read-for-ownership) from the next cycle.
- R10: A snooped command 0 on a Shared line, and a snooped command 3 on any line, cause no flush and leave the line unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cpu_req_valid | input | 1 | Processor request present |
| cpu_req_write | input | 1 | 1 = write, 0 = read |
| cpu_req_addr | input | ADDR_W | Word address; low IDX_W bits select the line |
| cpu_req_wdata | input | DATA_W | Write data |
| cpu_req_ready | output | 1 | Controller idle; request accepted when valid |
| cpu_resp_valid | output | 1 | One-cycle completion pulse |
| cpu_resp_rdata | output | DATA_W | Read data, or written data for a write |
| bus_req_valid | output | 1 | Bus request to the arbiter |
| bus_req_cmd | output | 2 | 0 read, 1 read-for-ownership, 2 upgrade, 3 write-back |
| bus_req_addr | output | ADDR_W | Request address (victim address for write-back) |
| bus_req_data | output | DATA_W | Victim data for write-back, else 0 |
| bus_grant | input | 1 | Grant; the transaction takes effect in this cycle |
| bus_fill_data | input | DATA_W | Line data returned with a read or read-for-ownership grant |
| snp_valid | input | 1 | Snooped transaction from another cache |
| snp_cmd | input | 2 | Snooped command, same encoding as bus_req_cmd |
| snp_addr | input | ADDR_W | Snooped address |
| flush_valid | output | 1 | Dirty data driven for a snoop |
| flush_addr | output | ADDR_W | Address of the flushed line |
| flush_data | output | DATA_W | Flushed data |

## Verification
The hardest situation to reach is a snoop that lands in the window after an upgrade has been requested and before it is granted. The grant must not slip in ahead of the snoop. The bench therefore holds its arbiter model off, waits until the upgrade shows on the bus, and injects a snooped upgrade to the same line. It then checks that the request turns into a read-for-ownership. Dirty-victim eviction is reached by writing one tag and then reading another tag at the same index, and the granted command order is logged.

// File: rtl/msi_pkg.sv
package msi_pkg;

    typedef enum logic [1:0] {
        LS_INV = 2'd0,
        LS_SHR = 2'd1,
        LS_MOD = 2'd2
    } line_state_e;

    typedef enum logic [1:0] {
        BC_READ  = 2'd0,
        BC_READX = 2'd1,
        BC_UPGR  = 2'd2,
        BC_WBACK = 2'd3
    } bus_cmd_e;

endpackage

// File: rtl/msi_line_array.sv
module msi_line_array
    import msi_pkg::*;
#(
    parameter int IDX_W  = 2,
    parameter int TAG_W  = 14,
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [IDX_W-1:0]  rd_a_idx,
    output line_state_e       rd_a_state,
    output logic [TAG_W-1:0]  rd_a_tag,
    output logic [DATA_W-1:0] rd_a_data,
    input  logic [IDX_W-1:0]  rd_b_idx,
    output line_state_e       rd_b_state,
    output logic [TAG_W-1:0]  rd_b_tag,
    output logic [DATA_W-1:0] rd_b_data,
    input  logic              wr_en,
    input  logic [IDX_W-1:0]  wr_idx,
    input  line_state_e       wr_state,
    input  logic              wr_tag_en,
    input  logic [TAG_W-1:0]  wr_tag,
    input  logic              wr_data_en,
    input  logic [DATA_W-1:0] wr_data
);
    localparam int DEPTH = 1 << IDX_W;

    typedef struct packed {
        line_state_e       st;
        logic [TAG_W-1:0]  tag;
        logic [DATA_W-1:0] dat;
    } entry_t;

    entry_t mem_d [DEPTH];
    entry_t mem_q [DEPTH];

    always_comb begin
        for (int i = 0; i < DEPTH; i++) begin
            mem_d[i] = mem_q[i];
        end
        if (wr_en) begin
            mem_d[wr_idx].st = wr_state;
            if (wr_tag_en) begin
                mem_d[wr_idx].tag = wr_tag;
            end
            if (wr_data_en) begin
                mem_d[wr_idx].dat = wr_data;
            end
        end
    end

    always_ff @(posedge clk) begin
        for (int i = 0; i < DEPTH; i++) begin
            if (!rst_n) begin
                mem_q[i] <= '{st: LS_INV, tag: '0, dat: '0};
            end else begin
                mem_q[i] <= mem_d[i];
            end
        end
    end

    assign rd_a_state = mem_q[rd_a_idx].st;
    assign rd_a_tag   = mem_q[rd_a_idx].tag;
    assign rd_a_data  = mem_q[rd_a_idx].dat;
    assign rd_b_state = mem_q[rd_b_idx].st;
    assign rd_b_tag   = mem_q[rd_b_idx].tag;
    assign rd_b_data  = mem_q[rd_b_idx].dat;

    AST_STATE_LEGAL: assert property (@(posedge clk) disable iff (!rst_n)
        rd_a_state != 2'd3) else $error("illegal line state"); // R1

endmodule

// File: rtl/msi_snoop_unit.sv
module msi_snoop_unit
    import msi_pkg::*;
#(
    parameter int ADDR_W    = 16,
    parameter int IDX_W     = 2,
    parameter int DATA_W    = 32,
    parameter bit MIGRATORY = 1'b0
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              snp_valid,
    input  logic [1:0]        snp_cmd,
    input  logic [ADDR_W-1:0] snp_addr,
    output logic [IDX_W-1:0]  snp_idx,
    input  line_state_e       line_state,
    input  logic [ADDR_W-IDX_W-1:0] line_tag,
    input  logic [DATA_W-1:0] line_data,
    output logic              upd_en,
    output line_state_e       upd_state,
    output logic              flush_valid,
    output logic [ADDR_W-1:0] flush_addr,
    output logic [DATA_W-1:0] flush_data
);
    localparam int TAG_W = ADDR_W - IDX_W;

    typedef struct packed {
        logic              vld;
        logic [ADDR_W-1:0] addr;
        logic [DATA_W-1:0] dat;
    } flush_t;

    flush_t fl_d, fl_q;
    logic   hit;
    logic   dirty;

    assign snp_idx = snp_addr[IDX_W-1:0];
    assign hit     = snp_valid && (line_state != LS_INV)
                     && (line_tag == snp_addr[ADDR_W-1:IDX_W]);
    assign dirty   = (line_state == LS_MOD);

    always_comb begin
        fl_d      = '{vld: 1'b0, addr: snp_addr, dat: line_data};
        upd_en    = 1'b0;
        upd_state = line_state;
        if (hit) begin
            unique case (bus_cmd_e'(snp_cmd))
                BC_READ: begin
                    if (dirty) begin
                        fl_d.vld  = 1'b1;
                        upd_en    = 1'b1;
                        upd_state = MIGRATORY ? LS_INV : LS_SHR;
                    end
                end
                BC_READX, BC_UPGR: begin
                    fl_d.vld  = dirty;
                    upd_en    = 1'b1;
                    upd_state = LS_INV;
                end
                default: begin
                end
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            fl_q <= '{vld: 1'b0, addr: '0, dat: '0};
        end else begin
            fl_q <= fl_d;
        end
    end

    assign flush_valid = fl_q.vld;
    assign flush_addr  = fl_q.addr;
    assign flush_data  = fl_q.dat;

    AST_FLUSH_AFTER_SNOOP: assert property (@(posedge clk) disable iff (!rst_n)
        flush_valid |-> $past(snp_valid)) else $error("flush without snoop"); // R7
    AST_FLUSH_ONLY_DIRTY: assert property (@(posedge clk) disable iff (!rst_n)
        flush_valid |-> $past(line_state == LS_MOD)) else $error("flush of clean line"); // R8

    logic [TAG_W-1:0] unused_w;
    assign unused_w = '0;

endmodule

// File: rtl/msi_req_ctrl.sv
module msi_req_ctrl
    import msi_pkg::*;
#(
    parameter int ADDR_W = 16,
    parameter int IDX_W  = 2,
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cpu_req_valid,
    input  logic              cpu_req_write,
    input  logic [ADDR_W-1:0] cpu_req_addr,
    input  logic [DATA_W-1:0] cpu_req_wdata,
    output logic              cpu_req_ready,
    output logic              cpu_resp_valid,
    output logic [DATA_W-1:0] cpu_resp_rdata,
    output logic              bus_req_valid,
    output logic [1:0]        bus_req_cmd,
    output logic [ADDR_W-1:0] bus_req_addr,
    output logic [DATA_W-1:0] bus_req_data,
    input  logic              bus_grant,
    input  logic [DATA_W-1:0] bus_fill_data,
    input  logic              snp_valid,
    output logic [IDX_W-1:0]  line_idx,
    input  line_state_e       line_state,
    input  logic [ADDR_W-IDX_W-1:0] line_tag,
    input  logic [DATA_W-1:0] line_data,
    output logic              upd_en,
    output line_state_e       upd_state,
    output logic              upd_tag_en,
    output logic [ADDR_W-IDX_W-1:0] upd_tag,
    output logic              upd_data_en,
    output logic [DATA_W-1:0] upd_data
);
    localparam int TAG_W = ADDR_W - IDX_W;

    typedef enum logic {PH_IDLE = 1'b0, PH_ACTIVE = 1'b1} phase_e;

    typedef struct packed {
        phase_e            ph;
        logic              wr;
        logic [ADDR_W-1:0] addr;
        logic [DATA_W-1:0] wdata;
        logic              rvld;
        logic [DATA_W-1:0] rdata;
    } req_t;

    req_t     r_d, r_q;
    logic [TAG_W-1:0] req_tag;
    logic     tag_hit;
    logic     need_bus;
    bus_cmd_e cmd;

    assign line_idx = r_q.addr[IDX_W-1:0];
    assign req_tag  = r_q.addr[ADDR_W-1:IDX_W];
    assign tag_hit  = (line_state != LS_INV) && (line_tag == req_tag);

    // Command is re-derived from the live line state every cycle.
    always_comb begin
        need_bus = 1'b1;
        cmd      = BC_READ;
        if (line_state == LS_MOD && !tag_hit) begin
            cmd = BC_WBACK;
        end else if (!tag_hit) begin
            cmd = r_q.wr ? BC_READX : BC_READ;
        end else if (r_q.wr && line_state == LS_SHR) begin
            cmd = BC_UPGR;
        end else begin
            need_bus = 1'b0;
        end
    end

    assign bus_req_valid = (r_q.ph == PH_ACTIVE) && need_bus;
    assign bus_req_cmd   = cmd;
    assign bus_req_addr  = (cmd == BC_WBACK) ? {line_tag, line_idx} : r_q.addr;
    assign bus_req_data  = (cmd == BC_WBACK) ? line_data : '0;

    always_comb begin
        r_d         = r_q;
        r_d.rvld    = 1'b0;
        upd_en      = 1'b0;
        upd_state   = line_state;
        upd_tag_en  = 1'b0;
        upd_tag     = req_tag;
        upd_data_en = 1'b0;
        upd_data    = bus_fill_data;
        cpu_req_ready = (r_q.ph == PH_IDLE);
        unique case (r_q.ph)
            PH_IDLE: begin
                if (cpu_req_valid) begin
                    r_d.ph    = PH_ACTIVE;
                    r_d.wr    = cpu_req_write;
                    r_d.addr  = cpu_req_addr;
                    r_d.wdata = cpu_req_wdata;
                end
            end
            PH_ACTIVE: begin
                if (!snp_valid) begin
                    if (!need_bus) begin
                        r_d.ph    = PH_IDLE;
                        r_d.rvld  = 1'b1;
                        r_d.rdata = r_q.wr ? r_q.wdata : line_data;
                        if (r_q.wr) begin
                            upd_en      = 1'b1;
                            upd_data_en = 1'b1;
                            upd_data    = r_q.wdata;
                        end
                    end else if (bus_grant) begin
                        upd_en = 1'b1;
                        unique case (cmd)
                            BC_READ: begin
                                upd_state   = LS_SHR;
                                upd_tag_en  = 1'b1;
                                upd_data_en = 1'b1;
                            end
                            BC_READX: begin
                                upd_state   = LS_MOD;
                                upd_tag_en  = 1'b1;
                                upd_data_en = 1'b1;
                            end
                            BC_UPGR:  upd_state = LS_MOD;
                            default:  upd_state = LS_INV;
                        endcase
                    end
                end
            end
            default: r_d.ph = PH_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            r_q <= '{ph: PH_IDLE, wr: 1'b0, addr: '0, wdata: '0, rvld: 1'b0, rdata: '0};
        end else begin
            r_q <= r_d;
        end
    end

    assign cpu_resp_valid = r_q.rvld;
    assign cpu_resp_rdata = r_q.rdata;

    AST_UPGR_ON_SHARED: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_req_valid && bus_req_cmd == BC_UPGR) |-> line_state == LS_SHR)
        else $error("upgrade without shared copy"); // R4
    AST_WB_ONLY_DIRTY: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_req_valid && bus_req_cmd == BC_WBACK) |-> line_state == LS_MOD)
        else $error("write-back of clean line"); // R6
    AST_RESP_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        cpu_resp_valid |=> !cpu_resp_valid) else $error("response longer than one cycle"); // R5
    AST_REQ_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_req_valid && !bus_grant && !snp_valid) |=> (bus_req_valid && $stable(bus_req_cmd)))
        else $error("bus request dropped without grant"); // R2

endmodule

// File: rtl/msi_snoop_ctrl.sv
module msi_snoop_ctrl
    import msi_pkg::*;
#(
    parameter int ADDR_W    = 16,
    parameter int IDX_W     = 2,
    parameter int DATA_W    = 32,
    parameter bit MIGRATORY = 1'b0
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cpu_req_valid,
    input  logic              cpu_req_write,
    input  logic [ADDR_W-1:0] cpu_req_addr,
    input  logic [DATA_W-1:0] cpu_req_wdata,
    output logic              cpu_req_ready,
    output logic              cpu_resp_valid,
    output logic [DATA_W-1:0] cpu_resp_rdata,
    output logic              bus_req_valid,
    output logic [1:0]        bus_req_cmd,
    output logic [ADDR_W-1:0] bus_req_addr,
    output logic [DATA_W-1:0] bus_req_data,
    input  logic              bus_grant,
    input  logic [DATA_W-1:0] bus_fill_data,
    input  logic              snp_valid,
    input  logic [1:0]        snp_cmd,
    input  logic [ADDR_W-1:0] snp_addr,
    output logic              flush_valid,
    output logic [ADDR_W-1:0] flush_addr,
    output logic [DATA_W-1:0] flush_data
);
    localparam int TAG_W = ADDR_W - IDX_W;

    logic [IDX_W-1:0]  a_idx, b_idx;
    line_state_e       a_state, b_state;
    logic [TAG_W-1:0]  a_tag, b_tag;
    logic [DATA_W-1:0] a_data, b_data;

    logic              rq_upd_en, rq_tag_en, rq_data_en;
    line_state_e       rq_state;
    logic [TAG_W-1:0]  rq_tag;
    logic [DATA_W-1:0] rq_data;
    logic              sn_upd_en;
    line_state_e       sn_state;

    logic              w_en, w_tag_en, w_data_en;
    logic [IDX_W-1:0]  w_idx;
    line_state_e       w_state;

    msi_req_ctrl #(.ADDR_W(ADDR_W), .IDX_W(IDX_W), .DATA_W(DATA_W)) u_req (
        .clk            (clk),
        .rst_n          (rst_n),
        .cpu_req_valid  (cpu_req_valid),
        .cpu_req_write  (cpu_req_write),
        .cpu_req_addr   (cpu_req_addr),
        .cpu_req_wdata  (cpu_req_wdata),
        .cpu_req_ready  (cpu_req_ready),
        .cpu_resp_valid (cpu_resp_valid),
        .cpu_resp_rdata (cpu_resp_rdata),
        .bus_req_valid  (bus_req_valid),
        .bus_req_cmd    (bus_req_cmd),
        .bus_req_addr   (bus_req_addr),
        .bus_req_data   (bus_req_data),
        .bus_grant      (bus_grant),
        .bus_fill_data  (bus_fill_data),
        .snp_valid      (snp_valid),
        .line_idx       (a_idx),
        .line_state     (a_state),
        .line_tag       (a_tag),
        .line_data      (a_data),
        .upd_en         (rq_upd_en),
        .upd_state      (rq_state),
        .upd_tag_en     (rq_tag_en),
        .upd_tag        (rq_tag),
        .upd_data_en    (rq_data_en),
        .upd_data       (rq_data)
    );

    msi_snoop_unit #(.ADDR_W(ADDR_W), .IDX_W(IDX_W), .DATA_W(DATA_W),
                     .MIGRATORY(MIGRATORY)) u_snoop (
        .clk         (clk),
        .rst_n       (rst_n),
        .snp_valid   (snp_valid),
        .snp_cmd     (snp_cmd),
        .snp_addr    (snp_addr),
        .snp_idx     (b_idx),
        .line_state  (b_state),
        .line_tag    (b_tag),
        .line_data   (b_data),
        .upd_en      (sn_upd_en),
        .upd_state   (sn_state),
        .flush_valid (flush_valid),
        .flush_addr  (flush_addr),
        .flush_data  (flush_data)
    );

    // Snoop updates win; the requester stalls whenever a snoop is present.
    always_comb begin
        w_en      = sn_upd_en | rq_upd_en;
        w_idx     = sn_upd_en ? b_idx : a_idx;
        w_state   = sn_upd_en ? sn_state : rq_state;
        w_tag_en  = !sn_upd_en && rq_tag_en;
        w_data_en = !sn_upd_en && rq_data_en;
    end

    msi_line_array #(.IDX_W(IDX_W), .TAG_W(TAG_W), .DATA_W(DATA_W)) u_array (
        .clk        (clk),
        .rst_n      (rst_n),
        .rd_a_idx   (a_idx),
        .rd_a_state (a_state),
        .rd_a_tag   (a_tag),
        .rd_a_data  (a_data),
        .rd_b_idx   (b_idx),
        .rd_b_state (b_state),
        .rd_b_tag   (b_tag),
        .rd_b_data  (b_data),
        .wr_en      (w_en),
        .wr_idx     (w_idx),
        .wr_state   (w_state),
        .wr_tag_en  (w_tag_en),
        .wr_tag     (rq_tag),
        .wr_data_en (w_data_en),
        .wr_data    (rq_data)
    );

    AST_SINGLE_WRITER: assert property (@(posedge clk) disable iff (!rst_n)
        !(sn_upd_en && rq_upd_en)) else $error("snoop and request both write"); // R8
    AST_READY_DROPS: assert property (@(posedge clk) disable iff (!rst_n)
        (cpu_req_valid && cpu_req_ready) |=> !cpu_req_ready) else $error("ready after accept"); // R5

endmodule

// File: tb/msi_snoop_ctrl_tb.sv
`timescale 1ns/1ps
module msi_snoop_ctrl_tb;
    localparam int AW = 16;
    localparam int IW = 2;
    localparam int DW = 32;
    localparam int NL = 1 << IW;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic cpu_req_valid = 1'b0, cpu_req_write = 1'b0;
    logic [AW-1:0] cpu_req_addr = '0;
    logic [DW-1:0] cpu_req_wdata = '0;
    logic cpu_req_ready, cpu_resp_valid;
    logic [DW-1:0] cpu_resp_rdata;
    logic bus_req_valid;
    logic [1:0] bus_req_cmd;
    logic [AW-1:0] bus_req_addr;
    logic [DW-1:0] bus_req_data;
    logic bus_grant = 1'b0;
    logic [DW-1:0] bus_fill_data;
    logic snp_valid = 1'b0;
    logic [1:0] snp_cmd = 2'd0;
    logic [AW-1:0] snp_addr = '0;
    logic flush_valid;
    logic [AW-1:0] flush_addr;
    logic [DW-1:0] flush_data;

    always #2 clk = ~clk;

    msi_snoop_ctrl #(.ADDR_W(AW), .IDX_W(IW), .DATA_W(DW), .MIGRATORY(1'b0)) u_dut (
        .clk(clk), .rst_n(rst_n),
        .cpu_req_valid(cpu_req_valid), .cpu_req_write(cpu_req_write),
        .cpu_req_addr(cpu_req_addr), .cpu_req_wdata(cpu_req_wdata),
        .cpu_req_ready(cpu_req_ready), .cpu_resp_valid(cpu_resp_valid),
        .cpu_resp_rdata(cpu_resp_rdata),
        .bus_req_valid(bus_req_valid), .bus_req_cmd(bus_req_cmd),
        .bus_req_addr(bus_req_addr), .bus_req_data(bus_req_data),
        .bus_grant(bus_grant), .bus_fill_data(bus_fill_data),
        .snp_valid(snp_valid), .snp_cmd(snp_cmd), .snp_addr(snp_addr),
        .flush_valid(flush_valid), .flush_addr(flush_addr), .flush_data(flush_data)
    );

    function automatic logic [DW-1:0] fill_of(input logic [AW-1:0] a);
        return {a, a ^ 16'h5A5A};
    endfunction
    assign bus_fill_data = fill_of(bus_req_addr);

    int n_checks = 0;
    int n_fail = 0;
    bit done = 1'b0;

    task automatic chk(input bit ok, input string req, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %0h expected %0h at %0t", req, what, act, exp, $time);
        end
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
            $finish;
        end
    endtask

    // ---------------- reference model ----------------
    int            m_st [NL];   // 0 invalid, 1 shared, 2 modified
    logic [AW-IW-1:0] m_tag [NL];
    logic [DW-1:0] m_dat [NL];
    bit            m_busy;
    bit            m_wr;
    logic [AW-1:0] m_addr;
    logic [DW-1:0] m_wdata;
    bit            m_rv;
    logic [DW-1:0] m_rdata;
    bit            m_fv;
    logic [AW-1:0] m_faddr;
    logic [DW-1:0] m_fdata;
    string         m_ftag = "R7";

    function automatic int model_cmd();
        int i;
        bit hit;
        i = int'(m_addr[IW-1:0]);
        hit = (m_st[i] != 0) && (m_tag[i] == m_addr[AW-1:IW]);
        if (m_st[i] == 2 && !hit) return 3;
        if (!hit) return m_wr ? 1 : 0;
        if (m_wr && m_st[i] == 1) return 2;
        return -1;
    endfunction

    always @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < NL; i++) begin
                m_st[i] = 0; m_tag[i] = '0; m_dat[i] = '0;
            end
            m_busy = 0; m_rv = 0; m_fv = 0;
        end else begin
            bit busy_pre;
            int c;
            int si;
            busy_pre = m_busy;
            m_rv = 0;
            m_fv = 0;
            if (snp_valid) begin
                si = int'(snp_addr[IW-1:0]);
                if (m_st[si] != 0 && m_tag[si] == snp_addr[AW-1:IW]) begin
                    if (snp_cmd == 2'd0 && m_st[si] == 2) begin
                        m_fv = 1; m_faddr = snp_addr; m_fdata = m_dat[si]; m_ftag = "R7";
                        m_st[si] = 1;
                    end else if (snp_cmd == 2'd1 || snp_cmd == 2'd2) begin
                        if (m_st[si] == 2) begin
                            m_fv = 1; m_faddr = snp_addr; m_fdata = m_dat[si]; m_ftag = "R8";
                        end
                        m_st[si] = 0;
                    end
                end
            end else if (busy_pre) begin
                si = int'(m_addr[IW-1:0]);
                c = model_cmd();
                if (c < 0) begin
                    m_rv = 1;
                    m_rdata = m_wr ? m_wdata : m_dat[si];
                    if (m_wr) m_dat[si] = m_wdata;
                    m_busy = 0;
                end else if (bus_grant) begin
                    case (c)
                        0: begin m_st[si] = 1; m_tag[si] = m_addr[AW-1:IW]; m_dat[si] = fill_of(m_addr); end
                        1: begin m_st[si] = 2; m_tag[si] = m_addr[AW-1:IW]; m_dat[si] = fill_of(m_addr); end
                        2: m_st[si] = 2;
                        default: m_st[si] = 0;
                    endcase
                end
            end
            if (!busy_pre && cpu_req_valid) begin
                m_busy = 1; m_wr = cpu_req_write; m_addr = cpu_req_addr; m_wdata = cpu_req_wdata;
            end
        end
    end

    function automatic string cmd_req(input int c);
        case (c)
            0: return "R2";
            1: return "R3";
            2: return "R4";
            default: return "R6";
        endcase
    endfunction

    // ---------------- per-cycle comparison ----------------
    always @(negedge clk) begin
        if (rst_n && !done) begin
            int c;
            int vi;
            logic [AW-1:0] ea;
            logic [DW-1:0] ed;
            c = m_busy ? model_cmd() : -1;
            chk(cpu_req_ready == !m_busy, "R5", "ready", 64'(cpu_req_ready), 64'(!m_busy));
            chk(bus_req_valid == (c >= 0), (c >= 0) ? cmd_req(c) : "R5", "bus_req_valid",
                64'(bus_req_valid), 64'(c >= 0));
            if (c >= 0 && bus_req_valid) begin
                vi = int'(m_addr[IW-1:0]);
                ea = (c == 3) ? {m_tag[vi], m_addr[IW-1:0]} : m_addr;
                ed = (c == 3) ? m_dat[vi] : '0;
                chk(bus_req_cmd == 2'(c), cmd_req(c), "bus_req_cmd", 64'(bus_req_cmd), 64'(c));
                chk(bus_req_addr == ea, cmd_req(c), "bus_req_addr", 64'(bus_req_addr), 64'(ea));
                chk(bus_req_data == ed, cmd_req(c), "bus_req_data", 64'(bus_req_data), 64'(ed));
            end
            chk(flush_valid == m_fv, m_ftag, "flush_valid", 64'(flush_valid), 64'(m_fv));
            if (m_fv && flush_valid) begin
                chk(flush_addr == m_faddr, m_ftag, "flush_addr", 64'(flush_addr), 64'(m_faddr));
                chk(flush_data == m_fdata, m_ftag, "flush_data", 64'(flush_data), 64'(m_fdata));
            end
            chk(cpu_resp_valid == m_rv, "R5", "resp_valid", 64'(cpu_resp_valid), 64'(m_rv));
            if (m_rv && cpu_resp_valid)
                chk(cpu_resp_rdata == m_rdata, "R2", "resp_rdata", 64'(cpu_resp_rdata), 64'(m_rdata));
        end
    end

    // ---------------- arbiter model ----------------
    bit grant_hold = 1'b0;
    logic [7:0] lfsr = 8'hA7;
    int grant_log [$];
    always @(negedge clk) begin
        lfsr = {lfsr[6:0], lfsr[7] ^ lfsr[5] ^ lfsr[4] ^ lfsr[3]};
        if (rst_n && !grant_hold && bus_req_valid && (lfsr[0] | lfsr[1])) begin
            bus_grant = 1'b1;
            grant_log.push_back(int'(bus_req_cmd));
        end else begin
            bus_grant = 1'b0;
        end
    end

    // ---------------- stimulus helpers ----------------
    task automatic cpu_op(input bit wr, input logic [AW-1:0] a, input logic [DW-1:0] d,
                          output logic [DW-1:0] rd);
        @(negedge clk);
        while (!cpu_req_ready) @(negedge clk);
        cpu_req_valid = 1'b1; cpu_req_write = wr; cpu_req_addr = a; cpu_req_wdata = d;
        @(negedge clk);
        cpu_req_valid = 1'b0;
        while (!cpu_resp_valid) @(negedge clk);
        rd = cpu_resp_rdata;
    endtask

    task automatic snoop(input logic [1:0] c, input logic [AW-1:0] a,
                         output bit fv, output logic [DW-1:0] fd);
        grant_hold = 1'b1;
        @(negedge clk);
        snp_valid = 1'b1; snp_cmd = c; snp_addr = a;
        @(negedge clk);
        snp_valid = 1'b0;
        fv = flush_valid; fd = flush_data;
        grant_hold = 1'b0;
    endtask

    localparam logic [AW-1:0] A0  = 16'h0010;
    localparam logic [AW-1:0] A0B = 16'h0020;
    localparam logic [AW-1:0] A1  = 16'h0011;
    localparam logic [AW-1:0] A1B = 16'h0021;

    initial begin
        repeat (50000) @(posedge clk);
        n_checks++; n_fail++;
        $display("FAIL watchdog: actual hung expected completion");
        finish_run();
    end

    initial begin
        logic [DW-1:0] rd;
        bit fv;
        logic [DW-1:0] fd;

        repeat (3) @(negedge clk);
        chk(cpu_req_ready == 1'b1, "R1", "ready in reset", 64'(cpu_req_ready), 64'd1);
        rst_n = 1'b1;
        @(negedge clk);
        chk(!bus_req_valid && !flush_valid && !cpu_resp_valid, "R1", "outputs after reset",
            {61'd0, bus_req_valid, flush_valid, cpu_resp_valid}, 64'd0);

        // R2: read miss fills Shared
        grant_log.delete();
        cpu_op(1'b0, A0, '0, rd);
        chk(rd == fill_of(A0), "R2", "read miss data", 64'(rd), 64'(fill_of(A0)));
        chk(grant_log.size() == 1 && grant_log[0] == 0, "R2", "read miss command",
            64'(grant_log.size()), 64'd1);
        // R5: read hit, no bus
        grant_log.delete();
        cpu_op(1'b0, A0, '0, rd);
        chk(grant_log.size() == 0, "R5", "read hit bus use", 64'(grant_log.size()), 64'd0);

        // R4: write to Shared upgrades
        cpu_op(1'b1, A0, 32'hCAFE0001, rd);
        chk(grant_log.size() == 1 && grant_log[0] == 2, "R4", "upgrade issued",
            64'(grant_log.size()), 64'd1);
        grant_log.delete();
        cpu_op(1'b1, A0, 32'hCAFE0002, rd);
        chk(grant_log.size() == 0, "R5", "write hit on modified", 64'(grant_log.size()), 64'd0);

        // R6: dirty victim written back before the read
        grant_log.delete();
        cpu_op(1'b0, A0B, '0, rd);
        chk(grant_log.size() == 2 && grant_log[0] == 3 && grant_log[1] == 0, "R6",
            "writeback then read", 64'(grant_log.size()), 64'd2);

        // R3: write miss
        grant_log.delete();
        cpu_op(1'b1, A1, 32'h1234ABCD, rd);
        chk(grant_log.size() == 1 && grant_log[0] == 1, "R3", "read-for-ownership",
            64'(grant_log.size()), 64'd1);
        cpu_op(1'b0, A1, '0, rd);
        chk(rd == 32'h1234ABCD, "R3", "written data read back", 64'(rd), 64'h1234ABCD);

        // R7: snooped read on Modified flushes and downgrades
        snoop(2'd0, A1, fv, fd);
        chk(fv && fd == 32'h1234ABCD, "R7", "flush on snooped read", 64'(fd), 64'h1234ABCD);
        grant_log.delete();
        cpu_op(1'b0, A1, '0, rd);
        chk(grant_log.size() == 0, "R7", "line still shared", 64'(grant_log.size()), 64'd0);

        // R9: pending upgrade invalidated before grant becomes read-for-ownership
        grant_hold = 1'b1;
        @(negedge clk);
        cpu_req_valid = 1'b1; cpu_req_write = 1'b1; cpu_req_addr = A1; cpu_req_wdata = 32'h0BAD0BAD;
        @(negedge clk);
        cpu_req_valid = 1'b0;
        chk(bus_req_valid && bus_req_cmd == 2'd2, "R9", "upgrade pending", 64'(bus_req_cmd), 64'd2);
        snp_valid = 1'b1; snp_cmd = 2'd2; snp_addr = A1;
        @(negedge clk);
        snp_valid = 1'b0;
        chk(bus_req_valid && bus_req_cmd == 2'd1, "R9", "reissued command", 64'(bus_req_cmd), 64'd1);
        chk(!flush_valid, "R8", "no flush for shared", 64'(flush_valid), 64'd0);
        grant_hold = 1'b0;
        while (!cpu_resp_valid) @(negedge clk);

        // R8: snooped read-for-ownership on Modified
        snoop(2'd1, A1, fv, fd);
        chk(fv && fd == 32'h0BAD0BAD, "R8", "flush before invalidate", 64'(fd), 64'h0BAD0BAD);
        grant_log.delete();
        cpu_op(1'b0, A1, '0, rd);
        chk(grant_log.size() == 1 && grant_log[0] == 0, "R8", "line invalid after snoop",
            64'(grant_log.size()), 64'd1);

        // R10: snooped read on Shared and snooped write-back ignored
        snoop(2'd0, A0B, fv, fd);
        chk(!fv, "R10", "no flush for shared read", 64'(fv), 64'd0);
        snoop(2'd3, A1, fv, fd);
        chk(!fv, "R10", "write-back snoop ignored", 64'(fv), 64'd0);
        snoop(2'd1, A1B, fv, fd);
        chk(!fv, "R8", "tag miss ignored", 64'(fv), 64'd0);
        grant_log.delete();
        cpu_op(1'b0, A1, '0, rd);
        cpu_op(1'b0, A0B, '0, rd);
        chk(grant_log.size() == 0, "R10", "lines unchanged", 64'(grant_log.size()), 64'd0);

        // R6: clean victim dropped silently
        grant_log.delete();
        cpu_op(1'b0, A1B, '0, rd);
        chk(grant_log.size() == 1 && grant_log[0] == 0, "R6", "clean victim no writeback",
            64'(grant_log.size()), 64'd1);

        // mixed traffic, compared cycle by cycle against the model
        for (int k = 0; k < 400; k++) begin
            logic [AW-1:0] a;
            a = AW'({$urandom_range(0, 3), 2'(IW'($urandom_range(0, NL - 1)))});
            if ($urandom_range(0, 3) == 0) begin
                snoop(2'($urandom_range(0, 3)), a, fv, fd);
            end else begin
                cpu_op(1'($urandom_range(0, 1)), a, $urandom, rd);
            end
        end

        repeat (4) @(negedge clk);
        finish_run();
    end

endmodule